// File: doc/BRIEF.md
# Tagged Receive FIFO

This block buffers the characters arriving on one serial receive channel. A deserializer in front of it strobes each character together with its parity-error, framing-error and break indications; the block stores the character and its flags as a single tagged entry in a 512-entry store. Software reads one tagged entry per access and gets the character and all line-condition flags for that character together. A fill-count output reports how many entries are held. A level-sensitive request line goes high when the fill level reaches a threshold chosen by a 2-bit trigger code.

Arrivals that find the store full are dropped. The loss is recorded by setting the overrun flag on the next entry that is stored, so software sees where the gap is in the stream. Software empties the store by holding a flush input high. A receive-enable input gates storage. A separate request-enable input gates the request line.

Occupancy is tracked by a four-state controller:
- `S_EMPTY`: nothing is held.
- `S_PARTIAL`: between one entry and one short of full.
- `S_FULL`: all 512 entries are held.
- `S_FLUSH`: the flush input is high.

Its transitions are:
- fill (`S_EMPTY`→`S_PARTIAL` on a stored character).
- top-up (`S_PARTIAL`→`S_FULL` when the last free slot is written without a read).
- drain-one (`S_FULL`→`S_PARTIAL` on a read without a write).
- drain-out (`S_PARTIAL`→`S_EMPTY` when the last entry is read without a write).
- flush-enter (any state→`S_FLUSH` while flush is high).
- flush-exit (`S_FLUSH`→`S_EMPTY`, or `S_FLUSH`→`S_PARTIAL` if a character is stored in the release cycle).

Top module: `rxq_tagged_fifo`

## Requirements
- R1: The store holds up to 512 entries. `fill_count` (16 bits) equals the number of held entries and never exceeds 512. After reset it is 0.
- R2: The read word places the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. Bits 15:12 read 0.
- R3: Each cycle with `rd_pop` high removes exactly one entry, oldest first. The removed entry appears on `rd_word` from the next clock edge and is held until the next pop.
- R4: A pop while the store is empty loads 0 into `rd_word` and leaves `fill_count` unchanged.
- R5: A character strobe (`rx_valid`) is stored only while `rx_enable` is 1. With `rx_enable` 0 the strobe changes neither `fill_count` nor any later read data.
- R6: A character arriving while the store is full, with no pop in the same cycle, is discarded and `fill_count` stays 512. The next stored entry carries bit 9 (overrun) set. Only that one entry carries it.
- R7: While `flush` is 1, `fill_count` is 0 from the next edge. Arriving characters are discarded, and pops return 0. After `flush` returns to 0, storage resumes normally.
- R8: `trig_sel` selects the threshold: code 0 means no request, code 1 means 1 entry, code 2 means 256 entries and code 3 means 448 entries. `rx_req` is 1 exactly while `fill_count` is at or above the selected threshold and `rx_irq_enable` is 1.
- R9: `rx_req` is a level, not a pulse. It stays high for as long as the R8 condition holds. It is 0 whenever `rx_irq_enable` is 0.
- R10: After reset, `rd_word` is 0, `fill_count` is 0 and `rx_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Store arriving characters when 1 |
| rx_irq_enable | input | 1 | Allow the request line when 1 |
| trig_sel | input | 2 | Request threshold code (0 off, 1, 256, 448) |
| flush | input | 1 | Empty the store while 1 |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error for this character |
| rx_frm_err | input | 1 | Framing error for this character |
| rx_brk | input | 1 | Break condition for this character |
| rd_pop | input | 1 | Read strobe, pops one entry |
| rd_word | output | 16 | Tagged entry returned by the last pop |
| fill_count | output | 16 | Number of entries held |
| rx_req | output | 1 | Receive-data request, level-sensitive |

## Verification
The overrun tag is the hardest behaviour to reach from the ports. It needs the store completely full (512 writes with no read), then a dropped arrival, then room made by one pop, then a fresh arrival. Only after the remaining 511 older entries are drained does the tagged entry reach `rd_word`. The stimulus fills the store with a computed character pattern and confirms the count pins at 512 across the extra arrival. It then drains the whole store, checking every entry's order and that exactly the refill entry carries bit 9. The two upper thresholds are approached the same way, with the request sampled one entry below and exactly at 256 and 448.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int ENTRY_W = 12;
    localparam int WORD_W  = 16;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2,
        S_FLUSH   = 2'd3
    } rxq_state_e;

    typedef enum logic [1:0] {
        TRG_OFF    = 2'd0,
        TRG_SINGLE = 2'd1,
        TRG_HALF   = 2'd2,
        TRG_HIGH   = 2'd3
    } trig_code_e;

    // Tagged entry layout: {break, framing, overrun, parity, char}
    function automatic logic [ENTRY_W-1:0] pack_entry(
        input logic [7:0] ch,
        input logic       par,
        input logic       ovr,
        input logic       frm,
        input logic       brk
    );
        return {brk, frm, ovr, par, ch};
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovr_tag,
    output logic [CW-1:0] count
);

    rxq_state_e state, nxt_state;
    logic       is_empty, is_full, drop;
    logic       ovr_pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= nxt_state;
    end

    // Output decode from state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state)
            S_EMPTY:   is_empty = 1'b1;
            S_PARTIAL: ;
            S_FULL:    is_full  = 1'b1;
            S_FLUSH:   is_empty = 1'b1;
            default:   is_empty = 1'b1;
        endcase
        pop_ok  = pop_req && !is_empty && !flush;
        push_ok = push_req && (!is_full || pop_ok);
        drop    = push_req && !push_ok;
        ovr_tag = ovr_pend;
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            S_EMPTY: begin
                if (flush)        nxt_state = S_FLUSH;
                else if (push_ok) nxt_state = S_PARTIAL;
            end
            S_PARTIAL: begin
                if (flush)
                    nxt_state = S_FLUSH;
                else if (push_ok && !pop_ok && count == CW'(DEPTH - 1))
                    nxt_state = S_FULL;
                else if (pop_ok && !push_ok && count == CW'(1))
                    nxt_state = S_EMPTY;
            end
            S_FULL: begin
                if (flush)                   nxt_state = S_FLUSH;
                else if (pop_ok && !push_ok) nxt_state = S_PARTIAL;
            end
            S_FLUSH: begin
                if (!flush) nxt_state = push_ok ? S_PARTIAL : S_EMPTY;
            end
            default: nxt_state = S_EMPTY;
        endcase
    end

    // Occupancy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (flush) count <= '0;
        else            count <= count + CW'(push_ok) - CW'(pop_ok);
    end

    // Pending overrun: set by a dropped arrival, consumed by the next store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_pend <= 1'b0;
        else if (flush)   ovr_pend <= 1'b0;
        else if (drop)    ovr_pend <= 1'b1;
        else if (push_ok) ovr_pend <= 1'b0;
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_empty_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY) |-> (count == '0));

    p_full_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FULL) |-> (count == CW'(DEPTH)));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push_req && !pop_req && !flush)
            |=> (count == CW'(DEPTH) && ovr_pend));

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !ovr_pend));

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req) |=> (count == '0));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push_ok,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic               pop_req,
    input  logic               pop_ok,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (pop_ok)  rd_data <= mem[rd_ptr];
        else if (pop_req) rd_data <= '0;
    end

    p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !pop_ok) |=> (rd_data == '0));

    p_hold_without_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> $stable(rd_data));

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int LVL_HALF = 256,
    parameter int LVL_HIGH = 448,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [1:0]    code,
    input  logic          irq_en,
    output logic          req
);

    logic [CW-1:0] thr;
    logic          thr_en;

    always_comb begin
        thr    = '0;
        thr_en = 1'b1;
        unique case (trig_code_e'(code))
            TRG_OFF:    thr_en = 1'b0;
            TRG_SINGLE: thr    = CW'(1);
            TRG_HALF:   thr    = CW'(LVL_HALF);
            TRG_HIGH:   thr    = CW'(LVL_HIGH);
            default:    thr_en = 1'b0;
        endcase
        req = irq_en && thr_en && (count >= thr);
    end

    p_req_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) && $stable(code) && $stable(irq_en) && count >= $past(count))
            |-> req);

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int LVL_HALF = 256,
    parameter int LVL_HIGH = 448
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic        rx_irq_enable,
    input  logic [1:0]  trig_sel,
    input  logic        flush,
    input  logic        rx_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_par_err,
    input  logic        rx_frm_err,
    input  logic        rx_brk,
    input  logic        rd_pop,
    output logic [15:0] rd_word,
    output logic [15:0] fill_count,
    output logic        rx_req
);

    localparam int CW = $clog2(DEPTH + 1);

    logic               push_req, push_ok, pop_ok, ovr_tag;
    logic [CW-1:0]      count;
    logic [ENTRY_W-1:0] wr_entry, rd_data;

    assign push_req = rx_valid && rx_enable && !flush;
    assign wr_entry = pack_entry(rx_char, rx_par_err, ovr_tag, rx_frm_err, rx_brk);

    rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (push_req),
        .pop_req  (rd_pop),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .ovr_tag  (ovr_tag),
        .count    (count)
    );

    rxq_store #(.DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_ok  (push_ok),
        .wr_entry (wr_entry),
        .pop_req  (rd_pop),
        .pop_ok   (pop_ok),
        .rd_data  (rd_data)
    );

    rxq_trigger #(
        .DEPTH    (DEPTH),
        .LVL_HALF (LVL_HALF),
        .LVL_HIGH (LVL_HIGH)
    ) i_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count),
        .code   (trig_sel),
        .irq_en (rx_irq_enable),
        .req    (rx_req)
    );

    assign rd_word    = {{(WORD_W - ENTRY_W){1'b0}}, rd_data};
    assign fill_count = 16'(count);

    p_req_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == 16'd0) |-> !rx_req);

    p_disabled_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rd_pop && !flush) |=> (fill_count == $past(fill_count)));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[15:12] == 4'd0);

endmodule

// File: tb/test_rxq_tagged_fifo.sv
`timescale 1ns/1ps
module test_rxq_tagged_fifo;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_enable, rx_irq_enable, flush, rx_valid;
    logic [1:0]  trig_sel;
    logic [7:0]  rx_char;
    logic        rx_par_err, rx_frm_err, rx_brk, rd_pop;
    logic [15:0] rd_word, fill_count;
    logic        rx_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rxq_tagged_fifo i_rxq_tagged_fifo (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .rx_irq_enable(rx_irq_enable), .trig_sel(trig_sel), .flush(flush),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rd_pop(rd_pop),
        .rd_word(rd_word), .fill_count(fill_count), .rx_req(rx_req)
    );

    // Vector: [35:34] op (0 push, 1 pop), [33:26] char, [25:23] {brk,frm,par},
    //         [22:11] expected word after a pop, [10:0] expected count
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 8'h41, 3'b000, 12'h000, 11'd1},
        {2'd0, 8'h42, 3'b001, 12'h000, 11'd2},
        {2'd0, 8'h43, 3'b010, 12'h000, 11'd3},
        {2'd0, 8'h00, 3'b100, 12'h000, 11'd4},
        {2'd1, 8'h00, 3'b000, 12'h041, 11'd3},
        {2'd1, 8'h00, 3'b000, 12'h142, 11'd2},
        {2'd1, 8'h00, 3'b000, 12'h443, 11'd1},
        {2'd1, 8'h00, 3'b000, 12'h800, 11'd0},
        {2'd1, 8'h00, 3'b000, 12'h000, 11'd0},
        {2'd0, 8'h5A, 3'b111, 12'h000, 11'd1},
        {2'd1, 8'h00, 3'b000, 12'hD5A, 11'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input logic [2:0] f);
        rx_valid = 1'b1; rx_char = c;
        rx_brk = f[2]; rx_frm_err = f[1]; rx_par_err = f[0];
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_char = '0; rx_brk = 0; rx_frm_err = 0; rx_par_err = 0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(posedge clk); #1;
        rd_pop = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 3 + 1) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int bad;
        rst_n = 1'b0; rx_enable = 1'b1; rx_irq_enable = 1'b1; trig_sel = 2'd1;
        flush = 1'b0; rx_valid = 1'b0; rx_char = '0; rx_par_err = 0;
        rx_frm_err = 0; rx_brk = 0; rd_pop = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 reset state
        check("R10 count", fill_count, 0);
        check("R10 req", rx_req, 0);
        check("R10 word", rd_word, 0);

        // R5 receive disabled
        rx_enable = 1'b0;
        push(8'hAA, 3'b111);
        check("R5 count unchanged", fill_count, 0);
        rx_enable = 1'b1;
        pop();
        check("R5 nothing stored", rd_word, 0);

        // Table: R2 layout, R3 order, R4 empty read
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35:34] == 2'd0) push(VEC[i][33:26], VEC[i][25:23]);
            else begin
                pop();
                check($sformatf("R2/R3 word vec%0d", i), rd_word, int'(VEC[i][22:11]));
            end
            check($sformatf("R1/R4 count vec%0d", i), fill_count, int'(VEC[i][10:0]));
        end

        // R8/R9 thresholds
        trig_sel = 2'd2;
        for (int i = 0; i < 255; i++) push(8'h11, 3'b000);
        check("R8 below 256", rx_req, 0);
        push(8'h11, 3'b000);
        check("R8 at 256", rx_req, 1);
        trig_sel = 2'd3; #1;
        check("R8 code3 at 256", rx_req, 0);
        for (int i = 0; i < 191; i++) push(8'h22, 3'b000);
        check("R8 at 447", rx_req, 0);
        push(8'h22, 3'b000);
        check("R8 at 448", rx_req, 1);
        repeat (3) @(posedge clk); #1;
        check("R9 level holds", rx_req, 1);
        trig_sel = 2'd0; #1;
        check("R8 code0 off", rx_req, 0);
        trig_sel = 2'd1; rx_irq_enable = 1'b0; #1;
        check("R9 irq disabled", rx_req, 0);
        rx_irq_enable = 1'b1; #1;
        check("R9 irq enabled", rx_req, 1);

        // R7 flush
        flush = 1'b1;
        @(posedge clk); #1;
        check("R7 flush count", fill_count, 0);
        check("R7 flush req", rx_req, 0);
        push(8'h99, 3'b000);
        check("R7 arrival dropped", fill_count, 0);
        pop();
        check("R7 pop during flush", rd_word, 0);
        flush = 1'b0;
        push(8'h3C, 3'b000);
        check("R7 resume count", fill_count, 1);
        pop();
        check("R7 resume word", rd_word, 16'h003C);

        // R1/R6 full and overrun
        for (int i = 0; i < 512; i++) push(pat(i), 3'b000);
        check("R1 full count", fill_count, 512);
        push(8'hEE, 3'b000);
        check("R6 full drop count", fill_count, 512);
        pop();
        check("R6 first word", rd_word, int'(pat(0)));
        check("R6 count after pop", fill_count, 511);
        push(8'h77, 3'b000);
        check("R6 refill count", fill_count, 512);
        bad = 0;
        for (int i = 1; i < 512; i++) begin
            pop();
            if (rd_word != {8'h00, pat(i)}) bad++;
        end
        check("R3 drain order", bad, 0);
        pop();
        check("R6 overrun tagged", rd_word, 16'h0277);
        check("R1 empty after drain", fill_count, 0);
        push(8'h10, 3'b000);
        pop();
        check("R6 tag only once", rd_word, 16'h0010);
        pop();
        check("R4 empty pop", rd_word, 0);
        check("R4 count", fill_count, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule